// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach the management registers of Ethernet PHYs over the two-wire MDIO bus. Software programs it through five 64-bit registers on a simple write/read port: a command register, a write-data register, a read-data register, a configuration register and an enable register. A write to the command register launches exactly one management frame. The block then generates MDC, shifts the frame out on MDIO and samples the reply. Completion is reported through pending and valid flags in the two data registers.

The framing variant is chosen by a sticky mode bit in the configuration register, not by the command. With the bit clear, frames use the Clause 22 layout. With it set, frames use the Clause 45 layout and the two-bit command op code is read differently. Multi-frame sequences are built by software. A Clause 45 access is one address frame followed by a read or write frame that names the same device.

The MDIO pin is split into an output, an output enable and an input so that it can be joined to a pad or a bus model outside the block.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset every register reads zero, MDC is low and MDIO is not driven (output enable low).
- R2: Enable register (byte offset 0x20) bit 0 gates the controller. While it is 0 a command write launches no frame and MDC stays low. Clearing it during a frame aborts the frame: MDC is low from the next cycle and both pending flags are 0.
- R3: Register readback, with all bits not listed reading zero. Configuration (0x18) keeps bits 7:0, 11:8, 12, 13, 15, 20:16 and 24, so all-ones reads 0x011FBFFF. Command (0x00) keeps register/device address 4:0, port address 12:8 and op code 17:16, so all-ones reads 0x31F1F. Of write data (0x08) only bits 15:0 are writable. Read data (0x10) is read-only. Enable reads as bit 0. A command write while a frame is in flight leaves the command register unchanged.
- R4: A Clause 22 write (config bit 24 = 0, op code 0) sends the following fields, MSB first: the optional preamble, start 01, op 01, the 5-bit port address, the 5-bit register address, turnaround 10, and the 16 write-data bits.
- R5: A Clause 22 read (op code 1) sends op 10. The 16 bits returned by the PHY land in read-data bits 15:0, MSB first. Valid (bit 16) is 1 and pending (bit 17) is 0 afterwards.
- R6: In Clause 45 mode (config bit 24 = 1), op code 0 sends an address frame: start 00, op 00, port, device address, turnaround 10, and the 16-bit write-data value.
- R7: In Clause 45 mode, op code 1 sends op 01 as a write. Op code 3 sends op 11 as a read, and op code 2 sends op 10 as a read.
- R8: Config bit 12 set prefixes the frame with 32 ones. When the bit is clear, a frame is 32 bits long and starts with the start field.
- R9: The MDC period during a frame is 2 x (config[7:0] + 1) system clocks.
- R10: MDIO changes only when MDC falls and is sampled when MDC rises. In a read, the output enable is low for the two turnaround bits and the 16 data bits.
- R11: A launch sets pending in read data (for reads) or in write data (for writes and address frames). Pending clears at the end of the frame, and write-data valid is then set to 1. A command write while a frame is pending starts nothing.
- R12: Read-data valid clears at launch and is set at the end only if the PHY held MDIO low at the first turnaround bit. The data field is updated at the end of every read.
- R13: In Clause 22 mode, op codes 2 and 3 are rejected: no frame starts and neither pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_addr | input | 6 | Register byte offset |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data (combinational from csr_addr) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A bench-side PHY responder captures each frame bit on the rising edge of MDC. It answers reads during turnaround and data, and the captured stream and output-enable pattern are compared with a frame built from the requirements.

The bench targets the corner cases that a faulty design would get wrong:
- A swapped op translation between the two modes would send 01 where 11 belongs.
- A preamble counted wrongly would shift every later field.
- A master that keeps driving through turnaround would show up in the output-enable pattern.
- A missing clear of valid at launch would let a stale good read survive a PHY that does not answer.
- Rejected Clause 22 op codes, commands written while pending, and an enable cleared mid-frame must each leave no frame and no pending flag behind.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int CSR_AW     = 6;
    localparam int CSR_DW     = 64;
    localparam int ADR_W      = 5;
    localparam int DATA_W     = 16;
    localparam int DIV_W      = 8;
    localparam int PRE_BITS   = 32;
    localparam int BODY_BITS  = 2 + 2 + 2 * ADR_W + 2 + DATA_W;
    localparam int FRAME_BITS = PRE_BITS + BODY_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_HI_IDX  = DATA_W + 1;

    localparam logic [CSR_AW-1:0] OFS_CMD  = 6'h00;
    localparam logic [CSR_AW-1:0] OFS_WDAT = 6'h08;
    localparam logic [CSR_AW-1:0] OFS_RDAT = 6'h10;
    localparam logic [CSR_AW-1:0] OFS_CFG  = 6'h18;
    localparam logic [CSR_AW-1:0] OFS_EN   = 6'h20;

    typedef struct packed {
        logic [1:0]       op;
        logic [ADR_W-1:0] port;
        logic [ADR_W-1:0] dev;
    } cmd_t;

    typedef struct packed {
        logic             ext45;
        logic [4:0]       smp_hi;
        logic             smp_mode;
        logic             idle_lvl;
        logic             pre_en;
        logic [3:0]       smp_pt;
        logic [DIV_W-1:0] half_div;
    } cfg_t;

    typedef struct packed {
        logic                  go;
        logic                  rd;
        logic                  pre;
        logic [FRAME_BITS-1:0] bits;
    } job_t;

    typedef struct packed {
        logic              fin;
        logic              rd;
        logic              ta_ok;
        logic [DATA_W-1:0] data;
    } res_t;

    function automatic logic op_legal(input logic ext45, input logic [1:0] op);
        return ext45 || !op[1];
    endfunction

    function automatic logic op_reads(input logic ext45, input logic [1:0] op);
        return ext45 ? op[1] : (op == 2'd1);
    endfunction

    function automatic logic [1:0] wire_op(input logic ext45, input logic [1:0] op);
        if (ext45) return op;
        return (op == 2'd0) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [FRAME_BITS-1:0] pack_frame(input logic ext45, input cmd_t c,
                                                         input logic [DATA_W-1:0] wd);
        logic              rd;
        logic [1:0]        st;
        logic [1:0]        ta;
        logic [DATA_W-1:0] pay;
        rd  = op_reads(ext45, c.op);
        st  = ext45 ? 2'b00 : 2'b01;
        ta  = rd ? 2'b11 : 2'b10;
        pay = rd ? {DATA_W{1'b1}} : wd;
        return {{PRE_BITS{1'b1}}, st, wire_op(ext45, c.op), c.port, c.dev, ta, pay};
    endfunction

    function automatic logic [CSR_DW-1:0] cmd_view(input cmd_t c);
        return CSR_DW'({c.op, 3'b000, c.port, 3'b000, c.dev});
    endfunction

    function automatic logic [CSR_DW-1:0] cfg_view(input cfg_t c);
        return CSR_DW'({c.ext45, 3'b000, c.smp_hi, c.smp_mode, 1'b0, c.idle_lvl,
                        c.pre_en, c.smp_pt, c.half_div});
    endfunction

    function automatic logic [CSR_DW-1:0] dat_view(input logic pend, input logic val,
                                                   input logic [DATA_W-1:0] d);
        return CSR_DW'({pend, val, d});
    endfunction

endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen
    import mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap     = run && (cnt_q == half_div);
    assign rise_evt = wrap && !mdc_q;
    assign fall_evt = wrap && mdc_q;
    assign mdc      = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // each MDC level lasts exactly half_div+1 clocks
    assert_half_period_R9: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (mdc_q != $past(mdc_q))) |-> ($past(cnt_q) == $past(half_div)));

endmodule

// File: rtl/mgmt_frame_shifter.sv
module mgmt_frame_shifter
    import mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  job_t job,
    input  logic enabled,
    input  logic rise_evt,
    input  logic fall_evt,
    input  logic mdio_i,
    output logic busy,
    output logic mdio_o,
    output logic mdio_oe,
    output res_t res
);

    logic [FRAME_BITS-1:0] frame_q;
    logic [IDX_W-1:0]      idx_q;
    logic [IDX_W-1:0]      idx_nx;
    logic [IDX_W-1:0]      idx_first;
    logic [DATA_W-1:0]     shift_q;
    logic                  busy_q;
    logic                  rd_q;
    logic                  ta_ok_q;
    logic                  mo_q;
    logic                  oe_q;
    res_t                  res_q;

    assign idx_nx    = idx_q - 1'b1;
    assign idx_first = job.pre ? IDX_W'(FRAME_BITS - 1) : IDX_W'(BODY_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            ta_ok_q <= 1'b0;
            mo_q    <= 1'b1;
            oe_q    <= 1'b0;
            res_q   <= '0;
        end else begin
            res_q.fin <= 1'b0;
            if (!enabled) begin
                busy_q <= 1'b0;
                oe_q   <= 1'b0;
                mo_q   <= 1'b1;
            end else if (job.go) begin
                busy_q  <= 1'b1;
                rd_q    <= job.rd;
                frame_q <= job.bits;
                idx_q   <= idx_first;
                mo_q    <= job.bits[idx_first];
                oe_q    <= 1'b1;
                ta_ok_q <= 1'b0;
            end else if (busy_q) begin
                if (rise_evt && rd_q) begin
                    if (idx_q == IDX_W'(TA_HI_IDX)) ta_ok_q <= !mdio_i;
                    if (idx_q < IDX_W'(DATA_W)) shift_q <= {shift_q[DATA_W-2:0], mdio_i};
                end
                if (fall_evt) begin
                    if (idx_q == '0) begin
                        busy_q     <= 1'b0;
                        oe_q       <= 1'b0;
                        mo_q       <= 1'b1;
                        res_q.fin  <= 1'b1;
                        res_q.rd   <= rd_q;
                        res_q.ta_ok<= ta_ok_q;
                        res_q.data <= shift_q;
                    end else begin
                        idx_q <= idx_nx;
                        mo_q  <= frame_q[idx_nx];
                        oe_q  <= !(rd_q && (idx_nx <= IDX_W'(TA_HI_IDX)));
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign mdio_o  = mo_q;
    assign mdio_oe = oe_q;
    assign res     = res_q;

    // MDIO is only driven while a frame is in flight
    assert_oe_in_frame_R11: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> busy_q);

    // pin released at every sampling point of turnaround and read data
    assert_ta_release_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && rise_evt && rd_q && (idx_q <= IDX_W'(TA_HI_IDX))) |-> !oe_q);

    // pin value changes only on a falling MDC event or at launch/end
    assert_drive_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && enabled && !$past(fall_evt) && !$past(job.go)) |-> $stable(mo_q));

endmodule

// File: rtl/mgmt_csr_bank.sv
module mgmt_csr_bank
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CSR_AW-1:0] addr,
    input  logic [CSR_DW-1:0] wdata,
    output logic [CSR_DW-1:0] rdata,
    input  logic              busy,
    input  res_t              res,
    output job_t              job,
    output cfg_t              cfg,
    output logic              enabled
);

    cmd_t              cmd_q;
    cfg_t              cfg_q;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] rdat_q;
    logic              wval_q;
    logic              wpend_q;
    logic              rval_q;
    logic              rpend_q;
    logic              en_q;
    cmd_t              cmd_in;
    cfg_t              cfg_in;
    logic              hit_cmd;
    logic              hit_wdat;
    logic              hit_cfg;
    logic              hit_en;
    logic              start;
    logic              unused_wbits;

    assign unused_wbits = ^wdata;

    assign hit_cmd  = wr_en && (addr == OFS_CMD);
    assign hit_wdat = wr_en && (addr == OFS_WDAT);
    assign hit_cfg  = wr_en && (addr == OFS_CFG);
    assign hit_en   = wr_en && (addr == OFS_EN);

    assign cmd_in.op   = wdata[17:16];
    assign cmd_in.port = wdata[12:8];
    assign cmd_in.dev  = wdata[4:0];

    assign cfg_in.half_div = wdata[7:0];
    assign cfg_in.smp_pt   = wdata[11:8];
    assign cfg_in.pre_en   = wdata[12];
    assign cfg_in.idle_lvl = wdata[13];
    assign cfg_in.smp_mode = wdata[15];
    assign cfg_in.smp_hi   = wdata[20:16];
    assign cfg_in.ext45    = wdata[24];

    assign start    = hit_cmd && en_q && !busy && op_legal(cfg_q.ext45, cmd_in.op);
    assign job.go   = start;
    assign job.rd   = op_reads(cfg_q.ext45, cmd_in.op);
    assign job.pre  = cfg_q.pre_en;
    assign job.bits = pack_frame(cfg_q.ext45, cmd_in, wdat_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            cfg_q   <= '0;
            wdat_q  <= '0;
            rdat_q  <= '0;
            wval_q  <= 1'b0;
            wpend_q <= 1'b0;
            rval_q  <= 1'b0;
            rpend_q <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            if (hit_wdat) wdat_q <= wdata[DATA_W-1:0];
            if (hit_cfg)  cfg_q  <= cfg_in;
            if (hit_en)   en_q   <= wdata[0];
            if (hit_cmd && !busy) cmd_q <= cmd_in;
            if (!en_q) begin
                wpend_q <= 1'b0;
                rpend_q <= 1'b0;
            end
            if (res.fin) begin
                if (res.rd) begin
                    rpend_q <= 1'b0;
                    rval_q  <= res.ta_ok;
                    rdat_q  <= res.data;
                end else begin
                    wpend_q <= 1'b0;
                    wval_q  <= 1'b1;
                end
            end
            if (start) begin
                if (job.rd) begin
                    rpend_q <= 1'b1;
                    rval_q  <= 1'b0;
                end else begin
                    wpend_q <= 1'b1;
                    wval_q  <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_CMD:  rdata = cmd_view(cmd_q);
            OFS_WDAT: rdata = dat_view(wpend_q, wval_q, wdat_q);
            OFS_RDAT: rdata = dat_view(rpend_q, rval_q, rdat_q);
            OFS_CFG:  rdata = cfg_view(cfg_q);
            OFS_EN:   rdata = CSR_DW'(en_q);
            default:  rdata = '0;
        endcase
    end

    assign cfg     = cfg_q;
    assign enabled = en_q;

    assert_pend_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wpend_q, rpend_q}));

    assert_no_start_off_R2: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !job.go);

    assert_rval_clear_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(rpend_q) |-> !rval_q);

    assert_c22_reject_R13: assert property (@(posedge clk) disable iff (rst)
        (hit_cmd && !cfg_q.ext45 && wdata[17]) |=> !$rose(wpend_q) && !$rose(rpend_q));

endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr_en,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    job_t job;
    cfg_t cfg;
    res_t res;
    logic enabled;
    logic busy;
    logic rise_evt;
    logic fall_evt;

    mgmt_csr_bank u_csr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (csr_wr_en),
        .addr    (csr_addr),
        .wdata   (csr_wdata),
        .rdata   (csr_rdata),
        .busy    (busy),
        .res     (res),
        .job     (job),
        .cfg     (cfg),
        .enabled (enabled)
    );

    mgmt_mdc_gen u_mdc (
        .clk      (clk),
        .rst      (rst),
        .run      (busy && enabled),
        .half_div (cfg.half_div),
        .mdc      (mdc_o),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mgmt_frame_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .job      (job),
        .enabled  (enabled),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .res      (res)
    );

    assert_mdc_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> !mdc_o);

endmodule

// File: tb/mgmt_serial_master_tb.sv
module mgmt_serial_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] A_CMD = 6'h00, A_WDAT = 6'h08, A_RDAT = 6'h10,
                           A_CFG = 6'h18, A_EN = 6'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr_en = 1'b0;
    logic [5:0]  csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        mdc_o, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mgmt_serial_master u_dut (
        .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct packed {
        logic [63:0] bits;
        logic [63:0] oe;
        logic [6:0]  len;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int n_chk = 0, n_fail = 0;
    int exp_frames = 0, frames_seen = 0;
    int cyc = 0, last_rise = 0, period = 0, rises = 0;
    int arm_id = 0, seen_arm = 0, k = 0, exp_len = 0;
    bit exp_rd = 0, ta0_val = 0;
    logic [15:0] rsp = '0;
    logic [63:0] obs_b = '0, obs_oe = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // PHY responder and monitor: capture on MDC rise, answer on MDC fall
    always @(posedge mdc_o) begin
        if (seen_arm != arm_id) begin
            seen_arm = arm_id;
            k = 0;
            obs_b = '0;
            obs_oe = '0;
        end
        period = cyc - last_rise;
        last_rise = cyc;
        rises++;
        obs_b  = {obs_b[62:0], (mdio_oe ? mdio_o : mdio_i)};
        obs_oe = {obs_oe[62:0], mdio_oe};
        k++;
        if (k == exp_len) begin
            frames_seen++;
            if (expq.size() == 0) begin
                chk("R11 unexpected frame", obs_b, 64'h0);
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk({t, " frame bits"}, obs_b, e.bits);
                chk("R10 output enable pattern", obs_oe, e.oe);
            end
        end
    end

    always @(negedge mdc_o) begin
        if (exp_rd && k < exp_len) begin
            int pos;
            pos = k - (exp_len - 32);
            if (pos == 14)      mdio_i = ta0_val;
            else if (pos == 15) mdio_i = 1'b0;
            else if (pos >= 16) mdio_i = rsp[31 - pos];
            else                mdio_i = 1'b1;
        end else begin
            mdio_i = 1'b1;
        end
    end

    task automatic csr_write(input logic [5:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_wr_en = 1'b1;
        csr_addr  = a;
        csr_wdata = d;
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic csr_read(input logic [5:0] a, output logic [63:0] v);
        @(negedge clk);
        csr_addr = a;
        #1;
        v = csr_rdata;
    endtask

    task automatic wait_idle(input logic [5:0] a);
        logic [63:0] v;
        int n;
        n = 0;
        do begin
            csr_read(a, v);
            n++;
        end while (v[17] && n < 5000);
    endtask

    // frame built from the field layout in the requirements
    task automatic run_frame(input string tag, input bit c45, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] wd, input bit rd, input bit ta0,
                             input logic [15:0] rv, input bit pre, input bit push);
        logic [1:0]  st, wop, ta;
        logic [15:0] pay;
        logic [31:0] body, oeb;
        exp_t e;
        st  = c45 ? 2'b00 : 2'b01;
        wop = c45 ? op : ((op == 2'd0) ? 2'b01 : 2'b10);
        ta  = rd ? {ta0, 1'b0} : 2'b10;
        pay = rd ? rv : wd;
        body = {st, wop, phy, ra, ta, pay};
        oeb  = rd ? {14'h3FFF, 18'h0} : 32'hFFFF_FFFF;
        e.bits = pre ? {32'hFFFF_FFFF, body} : {32'h0, body};
        e.oe   = pre ? {32'hFFFF_FFFF, oeb} : {32'h0, oeb};
        e.len  = pre ? 7'd64 : 7'd32;
        exp_len = int'(e.len);
        exp_rd  = rd;
        ta0_val = ta0;
        rsp     = rv;
        arm_id++;
        if (push) begin
            expq.push_back(e);
            tagq.push_back(tag);
            exp_frames++;
        end
        csr_write(A_CMD, {46'h0, op, 3'b000, phy, 3'b000, ra});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        int r0, f0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        csr_read(A_CMD, v);  chk("R1 cmd", v, 0);
        csr_read(A_WDAT, v); chk("R1 wdat", v, 0);
        csr_read(A_RDAT, v); chk("R1 rdat", v, 0);
        csr_read(A_CFG, v);  chk("R1 cfg", v, 0);
        csr_read(A_EN, v);   chk("R1 en", v, 0);
        chk("R1 mdc", 64'(mdc_o), 0);
        chk("R1 oe", 64'(mdio_oe), 0);

        // R3 readback masks
        csr_write(A_CFG, '1);  csr_read(A_CFG, v);  chk("R3 cfg mask", v, 64'h011F_BFFF);
        csr_write(A_CMD, '1);  csr_read(A_CMD, v);  chk("R3 cmd mask", v, 64'h3_1F1F);
        csr_write(A_WDAT, '1); csr_read(A_WDAT, v); chk("R3 wdat mask", v, 64'hFFFF);
        csr_write(A_RDAT, '1); csr_read(A_RDAT, v); chk("R3 rdat read-only", v, 0);

        // R2 disabled: no launch, MDC idle
        csr_write(A_CFG, 64'h1000);
        r0 = rises;
        run_frame("R2", 0, 2'd0, 5'd1, 5'd1, 16'hFFFF, 0, 0, 0, 1, 0);
        csr_read(A_WDAT, v); chk("R2 no pending while disabled", v, 64'hFFFF);
        repeat (40) @(posedge clk);
        chk("R2 mdc idle while disabled", 64'(rises), 64'(r0));

        csr_write(A_EN, '1); csr_read(A_EN, v); chk("R3 en mask", v, 1);

        // R4 / R8 / R9 / R11: Clause 22 write with preamble, phase 3
        csr_write(A_CFG, 64'h1003);
        csr_write(A_WDAT, 64'hA55A);
        run_frame("R4", 0, 2'd0, 5'd5, 5'h12, 16'hA55A, 0, 0, 0, 1, 1);
        csr_read(A_WDAT, v); chk("R11 pending at launch", v, 64'h2_A55A);
        wait_idle(A_WDAT);
        csr_read(A_WDAT, v); chk("R11 write done valid", v, 64'h1_A55A);
        chk("R9 period phase 3", 64'(period), 8);

        // R5 / R10 / R9: Clause 22 read, phase 0
        csr_write(A_CFG, 64'h1000);
        run_frame("R5", 0, 2'd1, 5'h1F, 5'h01, 16'h0, 1, 0, 16'h1234, 1, 1);
        wait_idle(A_RDAT);
        csr_read(A_RDAT, v); chk("R5 read data valid", v, 64'h1_1234);
        chk("R9 period phase 0", 64'(period), 2);

        // R12: valid cleared at launch, stays low when TA0 is high
        run_frame("R12", 0, 2'd1, 5'h03, 5'h04, 16'h0, 1, 1, 16'hBEEF, 1, 1);
        csr_read(A_RDAT, v); chk("R12 valid cleared at launch", v, 64'h2_1234);
        wait_idle(A_RDAT);
        csr_read(A_RDAT, v); chk("R12 no-answer read invalid", v, 64'h0_BEEF);

        // R8: no preamble
        csr_write(A_CFG, 64'h0001);
        csr_write(A_WDAT, 64'h0F0F);
        run_frame("R8", 0, 2'd0, 5'h0A, 5'h15, 16'h0F0F, 0, 0, 0, 0, 1);
        wait_idle(A_WDAT);
        chk("R8 frame count", 64'(frames_seen), 64'(exp_frames));

        // R6 / R7: Clause 45 sequence
        csr_write(A_CFG, 64'h0100_1001);
        csr_write(A_WDAT, 64'hBEEF);
        run_frame("R6", 1, 2'd0, 5'd2, 5'd3, 16'hBEEF, 0, 0, 0, 1, 1);
        wait_idle(A_WDAT);
        csr_read(A_WDAT, v); chk("R6 address frame done", v, 64'h1_BEEF);
        csr_write(A_WDAT, 64'h5555);
        run_frame("R7 write", 1, 2'd1, 5'd2, 5'd3, 16'h5555, 0, 0, 0, 1, 1);
        wait_idle(A_WDAT);
        run_frame("R7 read", 1, 2'd3, 5'd2, 5'd3, 16'h0, 1, 0, 16'hC0DE, 1, 1);
        wait_idle(A_RDAT);
        csr_read(A_RDAT, v); chk("R7 clause 45 read data", v, 64'h1_C0DE);

        // R13: Clause 22 op 2 rejected
        csr_write(A_CFG, 64'h1001);
        f0 = frames_seen;
        csr_write(A_CMD, 64'h2_0101);
        csr_read(A_WDAT, v); chk("R13 no write pending", 64'(v[17]), 0);
        csr_read(A_RDAT, v); chk("R13 read data untouched", v, 64'h1_C0DE);
        repeat (300) @(posedge clk);
        chk("R13 no frame", 64'(frames_seen), 64'(f0));

        // R11: command while pending ignored
        run_frame("R11", 0, 2'd0, 5'd1, 5'd2, 16'h5555, 0, 0, 0, 1, 1);
        csr_write(A_CMD, 64'h1_0707);
        csr_read(A_CMD, v); chk("R3 cmd held while busy", v, 64'h0_0102);
        csr_read(A_RDAT, v); chk("R11 second command no read pending", 64'(v[17]), 0);
        wait_idle(A_WDAT);
        repeat (300) @(posedge clk);
        chk("R11 one frame only", 64'(frames_seen), 64'(exp_frames));

        // R2: abort mid-frame
        run_frame("R2", 0, 2'd0, 5'd9, 5'd9, 16'h5555, 0, 0, 0, 1, 0);
        repeat (30) @(posedge clk);
        csr_write(A_EN, 64'h0);
        csr_read(A_WDAT, v); chk("R2 abort clears pending", 64'(v[17]), 0);
        chk("R2 mdc low after abort", 64'(mdc_o), 0);
        r0 = rises;
        repeat (100) @(posedge clk);
        chk("R2 mdc stays idle", 64'(rises), 64'(r0));
        csr_write(A_EN, 64'h1);
        run_frame("R4 after abort", 0, 2'd0, 5'd6, 5'd7, 16'h5555, 0, 0, 0, 1, 1);
        wait_idle(A_WDAT);
        repeat (20) @(posedge clk);

        chk("R4 scoreboard drained", 64'(expq.size()), 0);
        chk("R11 frames seen", 64'(frames_seen), 64'(exp_frames));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule